// File: doc/BRIEF.md
# Conditional Instruction Control Decoder

This block is the purely combinational control stage of a small 16-bit processor. It reads three inputs: the 4-bit opcode of the current instruction, the instruction's condition bit, and the zero flag held in the processor's flag register. From these it produces every control signal the datapath needs to execute that instruction.

The outputs are the register write enable, the memory write enable and the flag-update enable. It also drives a 2-bit selector that picks the source of the value written back, and a 2-bit ALU operation code. A single execute term decides whether the instruction takes effect. That term is exported so that a status indicator or a trace unit can follow it.

A conditional instruction whose condition fails behaves as a no-op. It changes no register, no memory word and no flag. The sequencer can therefore still advance the program counter as normal. Opcodes that have no assigned meaning are made harmless: they never write anything.

Top module: `cond_ctrl_decoder`

## Requirements
- R1: The execute output `exec_o` is 1 when `cond_i` is 0, and also when `cond_i` is 1 and `zflag_i` is 1; it is 0 only for `cond_i`=1 with `zflag_i`=0.
- R2: Whenever `exec_o` is 0, `reg_we_o`, `mem_we_o` and `flag_we_o` are all 0, for every opcode.
- R3: `flag_we_o` is 1 exactly for opcodes 4'b1000, 4'b1001, 4'b1010 and 4'b1011 while `exec_o` is 1.
- R4: `mem_we_o` is 1 exactly for opcode 4'b0100 (store) while `exec_o` is 1.
- R5: `reg_we_o` is 1 exactly for opcodes 4'b0000, 4'b0001, 4'b0101 and 4'b1000 to 4'b1011 while `exec_o` is 1.
- R6: `res_sel_o` encodes the write-back source: 2'b01 for opcode 4'b0000 (zero-extended immediate), 2'b10 for 4'b0001 (immediate into the high byte, old low byte kept), 2'b11 for 4'b0101 (memory data) and 2'b00 (ALU result) for every other opcode; it does not depend on `cond_i` or `zflag_i`.
- R7: `alu_op_o` equals opcode bits [1:0] for opcodes 4'b1000 to 4'b1011 (00 add, 01 sub, 10 and, 11 or) and is 2'b00 for all other opcodes, whatever `cond_i` and `zflag_i` are.
- R8: Opcodes 4'b0010, 4'b0011, 4'b0110, 4'b0111 and 4'b1100 to 4'b1111 keep all three write enables at 0 for every value of `cond_i` and `zflag_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Opcode field of the current instruction |
| cond_i | input | 1 | Condition bit: 1 makes the instruction depend on the zero flag |
| zflag_i | input | 1 | Stored zero flag from the flag register |
| exec_o | output | 1 | Instruction takes effect this cycle |
| reg_we_o | output | 1 | Register file write enable |
| mem_we_o | output | 1 | Data memory write enable |
| flag_we_o | output | 1 | Flag register update enable |
| res_sel_o | output | 2 | Write-back source select |
| alu_op_o | output | 2 | ALU operation code |

## Verification
The block holds no state, so any fault in the opcode classification or in the execute term shows up at the ports in the same evaluation as the offending input combination. A wrong execute term appears as a write enable that is set for a failed condition, or missing for a passing one. A wrong class decode appears as a wrong selector or ALU code, or as a write from an undefined opcode. All 64 combinations of opcode, condition bit and zero flag are applied, so every such error reaches a compared output.

// File: rtl/cond_ctrl_pkg.sv
package cond_ctrl_pkg;

  localparam int unsigned OP_W  = 4;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned AOP_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_ALU    = 2'b00,
    SRC_IMM_LO = 2'b01,
    SRC_HI_MRG = 2'b10,
    SRC_MEM    = 2'b11
  } wb_src_t;

  localparam logic [OP_W-1:0] OPC_MOVLO = 4'b0000;
  localparam logic [OP_W-1:0] OPC_SETHI = 4'b0001;
  localparam logic [OP_W-1:0] OPC_STORE = 4'b0100;
  localparam logic [OP_W-1:0] OPC_LOAD  = 4'b0101;

  // Instruction passes its condition
  function automatic logic cond_pass(input logic cond, input logic z);
    return (!cond) || z;
  endfunction

  // Arithmetic/logic class: top two opcode bits are 10
  function automatic logic is_alu_class(input logic [OP_W-1:0] op);
    return op[OP_W-1:OP_W-2] == 2'b10;
  endfunction

endpackage

// File: rtl/cond_exec_gate.sv
module cond_exec_gate
  import cond_ctrl_pkg::*;
(
  input  logic cond_i,
  input  logic zflag_i,
  output logic exec_o
);

  always_comb begin
    exec_o = cond_pass(cond_i, zflag_i);
  end

  // R1
  always_comb begin
    if (!$isunknown({cond_i, exec_o}) && !cond_i) begin
      uncond_runs_chk: assert (exec_o)
        else $error("unconditional instruction suppressed");
    end
  end

endmodule

// File: rtl/cond_op_class.sv
module cond_op_class
  import cond_ctrl_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  output logic             want_reg_o,
  output logic             want_mem_o,
  output logic             want_flag_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [AOP_W-1:0] aop_o
);

  logic    alu_cls;
  wb_src_t src;

  always_comb begin
    alu_cls     = is_alu_class(op_i);
    want_reg_o  = 1'b0;
    want_mem_o  = 1'b0;
    want_flag_o = 1'b0;
    src         = SRC_ALU;
    aop_o       = '0;
    if (alu_cls) begin
      want_reg_o  = 1'b1;
      want_flag_o = 1'b1;
      aop_o       = op_i[AOP_W-1:0];
    end else begin
      unique case (op_i)
        OPC_MOVLO: begin want_reg_o = 1'b1; src = SRC_IMM_LO; end
        OPC_SETHI: begin want_reg_o = 1'b1; src = SRC_HI_MRG; end
        OPC_LOAD:  begin want_reg_o = 1'b1; src = SRC_MEM;    end
        OPC_STORE: begin want_mem_o = 1'b1;                   end
        default:   begin                                      end
      endcase
    end
    sel_o = src;
  end

  // R3
  always_comb begin
    if (!$isunknown({op_i, want_flag_o}) && want_flag_o) begin
      flag_only_alu_chk: assert (op_i[3] && !op_i[2])
        else $error("flag intent for non-ALU opcode %b", op_i);
    end
  end

  // R4
  always_comb begin
    if (!$isunknown({op_i, want_mem_o, want_reg_o}) && want_mem_o) begin
      store_no_reg_chk: assert (op_i == 4'b0100 && !want_reg_o)
        else $error("memory intent on opcode %b", op_i);
    end
  end

endmodule

// File: rtl/cond_ctrl_decoder.sv
module cond_ctrl_decoder
  import cond_ctrl_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic       cond_i,
  input  logic       zflag_i,
  output logic       exec_o,
  output logic       reg_we_o,
  output logic       mem_we_o,
  output logic       flag_we_o,
  output logic [1:0] res_sel_o,
  output logic [1:0] alu_op_o
);

  logic             run;
  logic             want_reg;
  logic             want_mem;
  logic             want_flag;
  logic [SEL_W-1:0] sel;
  logic [AOP_W-1:0] aop;

  cond_exec_gate u_gate (
    .cond_i  (cond_i),
    .zflag_i (zflag_i),
    .exec_o  (run)
  );

  cond_op_class u_cls (
    .op_i        (op_i),
    .want_reg_o  (want_reg),
    .want_mem_o  (want_mem),
    .want_flag_o (want_flag),
    .sel_o       (sel),
    .aop_o       (aop)
  );

  // The single execute term gates every side effect
  always_comb begin
    exec_o    = run;
    reg_we_o  = want_reg  & run;
    mem_we_o  = want_mem  & run;
    flag_we_o = want_flag & run;
    res_sel_o = sel;
    alu_op_o  = aop;
  end

  // R2
  always_comb begin
    if (!$isunknown({exec_o, reg_we_o, mem_we_o, flag_we_o}) && !exec_o) begin
      skip_no_write_chk: assert (!reg_we_o && !mem_we_o && !flag_we_o)
        else $error("write enable while not executing");
    end
  end

  // R8
  always_comb begin
    if (!$isunknown({op_i, reg_we_o, mem_we_o, flag_we_o}) &&
        (op_i[3:1] == 3'b001 || op_i[3:1] == 3'b011 || op_i[3:2] == 2'b11)) begin
      undef_harmless_chk: assert (!reg_we_o && !mem_we_o && !flag_we_o)
        else $error("undefined opcode %b writes", op_i);
    end
  end

  // R7
  always_comb begin
    if (!$isunknown({op_i, alu_op_o}) && op_i[3:2] != 2'b10) begin
      aop_idle_chk: assert (alu_op_o == 2'b00)
        else $error("ALU code %b for non-ALU opcode", alu_op_o);
    end
  end

endmodule

// File: tb/cond_ctrl_decoder_bench.sv
module cond_ctrl_decoder_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = 4'b0000;
  logic       cond_i = 1'b1;
  logic       zflag_i = 1'b0;
  logic       exec_o, reg_we_o, mem_we_o, flag_we_o;
  logic [1:0] res_sel_o, alu_op_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cond_ctrl_decoder u_cond_ctrl_decoder (
    .op_i      (op_i),
    .cond_i    (cond_i),
    .zflag_i   (zflag_i),
    .exec_o    (exec_o),
    .reg_we_o  (reg_we_o),
    .mem_we_o  (mem_we_o),
    .flag_we_o (flag_we_o),
    .res_sel_o (res_sel_o),
    .alu_op_o  (alu_op_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Apply one combination and compare every output with the table
  task automatic apply(input logic [3:0] op, input logic c, input logic z);
    bit       ex, rw, mw, fw;
    bit [1:0] sl, ao;
    @(posedge clk);
    op_i = op; cond_i = c; zflag_i = z;
    ex = (c == 1'b0) || (z == 1'b1);
    rw = 0; mw = 0; fw = 0; sl = 2'b00; ao = 2'b00;
    case (op)
      4'b0000: begin rw = 1; sl = 2'b01; end
      4'b0001: begin rw = 1; sl = 2'b10; end
      4'b0100: mw = 1;
      4'b0101: begin rw = 1; sl = 2'b11; end
      4'b1000, 4'b1001, 4'b1010, 4'b1011: begin rw = 1; fw = 1; ao = op[1:0]; end
      default: ;
    endcase
    @(negedge clk);
    chk("R1", "exec", int'(exec_o), int'(ex));
    chk("R5", "reg_we", int'(reg_we_o), int'(rw && ex));
    chk("R4", "mem_we", int'(mem_we_o), int'(mw && ex));
    chk("R3", "flag_we", int'(flag_we_o), int'(fw && ex));
    chk("R6", "res_sel", int'(res_sel_o), int'(sl));
    chk("R7", "alu_op", int'(alu_op_o), int'(ao));
    if (!ex) chk("R2", "any_we", int'(reg_we_o | mem_we_o | flag_we_o), 0);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    chk("R2", "reset_exec", int'(exec_o), 0);
    chk("R2", "reset_we", int'(reg_we_o | mem_we_o | flag_we_o), 0);
  endtask

  task automatic t_unconditional;
    for (int o = 0; o < 16; o++) begin
      apply(4'(o), 1'b0, 1'b0);
      apply(4'(o), 1'b0, 1'b1);
    end
  endtask

  task automatic t_cond_taken;
    for (int o = 0; o < 16; o++) apply(4'(o), 1'b1, 1'b1);
  endtask

  task automatic t_cond_skipped;
    for (int o = 0; o < 16; o++) apply(4'(o), 1'b1, 1'b0);
  endtask

  task automatic t_undefined;
    // R8: undefined opcodes never write under any condition
    for (int o = 0; o < 16; o++) begin
      if (o == 2 || o == 3 || o == 6 || o == 7 || o >= 12) begin
        for (int k = 0; k < 4; k++) begin
          apply(4'(o), k[1], k[0]);
          chk("R8", "undef_we", int'(reg_we_o | mem_we_o | flag_we_o), 0);
        end
      end
    end
  endtask

  task automatic t_store_skip;
    // R4: conditional store with Z clear writes nothing, then with Z set it writes
    apply(4'b0100, 1'b1, 1'b0);
    chk("R4", "store_skip", int'(mem_we_o), 0);
    apply(4'b0100, 1'b1, 1'b1);
    chk("R4", "store_take", int'(mem_we_o), 1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_unconditional();
    t_cond_taken();
    t_cond_skipped();
    t_undefined();
    t_store_skip();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule